// File: doc/BRIEF.md
# Virtual Tributary Circuit-Emulation Packetizer

This block sits on the ingress side of a circuit-emulation edge. It takes the byte stream of one virtual tributary, which may be VT1.5, VT2, VT3 or VT6, together with a marker on the first byte of each four-frame multiframe. It cuts the stream into fixed-size payload fragments and puts a 32-bit emulation header in front of each fragment. The header holds four things:

- a pointer that locates one reference byte inside the fragment;
- a 14-bit sequence number;
- a remote-defect flag and a bandwidth/unequipped flag;
- two flags that report pointer adjustments or an AIS-V condition.

There are two modes. In structured mode the four tributary overhead bytes (V1 to V4) are removed, and the pointer locates the path-overhead byte V5. The V5 byte is flagged by an upstream pointer interpreter. In unstructured mode every byte is kept and the pointer locates V1. A pointer of 0x1FF means the reference byte is not in that fragment.

Each fragment is collected in one half of a two-bank buffer. It is then sent as a contiguous output burst, header first, with start and end markers. The pointer is known only once the fragment is complete. This lets the header go out ahead of its payload.

Top module: `vtpkt_packetizer`

## Requirements
- R1: Each packet is sent as four header bytes, most significant byte first, followed by the payload bytes. The header word is {1'b0, R, D, N, P, pointer[12:0], sequence[13:0]} from bit 31 down to bit 0. `out_sop` marks the first header byte, `out_eop` marks the last payload byte, and `out_valid` drops for at least one cycle after `out_eop`.
- R2: The multiframe length depends on the `cfg_kind` code: 0 gives 108 bytes, 1 gives 144, 2 gives 216 and 3 gives 432. The byte flagged by `in_mf_start` is V1. The overhead bytes are the first byte of each quarter of the multiframe, counted from V1.
- R3: In structured mode (`cfg_structured`=1) the overhead bytes do not appear in the payload. In unstructured mode every accepted byte appears, in input order.
- R4: In structured mode the pointer is the payload offset (0 is the first byte after the header) of the byte flagged by `in_v5`. It is 0x1FF when that byte is not in the fragment.
- R5: In unstructured mode the pointer is the payload offset of the V1 byte, or 0x1FF when V1 is not in the fragment.
- R6: The first packet after reset carries sequence 0. Each later packet carries the previous value plus one, and 16383 is followed by 0.
- R7: A one-cycle `neg_evt` or `pos_evt` strobe sets N or P in the next packet to be completed, including a packet completed in the same cycle. The flag is then cleared. In unstructured mode N and P are always 0.
- R8: In structured mode, while `ais_v` is high at packet completion, both N and P are 1 whatever events occurred.
- R9: R equals `rdi` and D equals `dba_flag`, both sampled in the cycle the packet's last payload byte is accepted.
- R10: The payload length is `cfg_len` limited to the range 1 to L. L is the multiframe length in unstructured mode, or the multiframe length minus 4 in structured mode.
- R11: Bytes before the first V1 after reset are discarded. Type, mode and length are taken from the configuration only when a fragment begins on a V1 byte. A change made at any other time waits for such a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Tributary byte present |
| in_byte | input | 8 | Tributary byte |
| in_mf_start | input | 1 | Byte is V1, the first byte of a multiframe |
| in_v5 | input | 1 | Byte is the V5 path-overhead byte |
| neg_evt | input | 1 | Negative pointer adjustment strobe |
| pos_evt | input | 1 | Positive pointer adjustment strobe |
| ais_v | input | 1 | AIS-V condition level |
| rdi | input | 1 | Remote defect level |
| dba_flag | input | 1 | Bandwidth/unequipped indication level |
| cfg_kind | input | 2 | Tributary type code |
| cfg_structured | input | 1 | 1 = structured mode |
| cfg_len | input | 9 | Requested payload bytes per packet |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Header or payload byte |
| out_sop | output | 1 | First header byte |
| out_eop | output | 1 | Last payload byte |

## Verification
Two functions can fall in the same cycle.

The first pair is the pointer-event latch and the completion of a fragment. The bench raises a negative-adjustment strobe on the very byte that completes a structured fragment. It raises a positive strobe on the following V1 byte, which is dropped as overhead. The first event must appear in the packet just completed and the second in the packet after it.

The second pair is configuration loading and the start of a fragment. The bench changes the requested length mid-packet in a stream whose fragments start on V1 only every second packet. The new length must first appear at the next V1-aligned fragment. The bench's own arithmetic model predicts every header and payload byte, and the whole output stream is compared against it in order.

// File: rtl/vtpkt_pkg.sv
package vtpkt_pkg;

  localparam int PTR_W  = 13;
  localparam int SEQ_W  = 14;
  localparam int QTR_W  = 7;
  localparam logic [PTR_W-1:0] PTR_NONE = 13'h1FF;

  typedef enum logic [1:0] {
    EM_IDLE = 2'd0,
    EM_HDR  = 2'd1,
    EM_PAY  = 2'd2
  } em_state_e;

  // Bytes in one four-frame multiframe for each tributary type code.
  function automatic logic [8:0] mf_bytes(input logic [1:0] kind);
    case (kind)
      2'd0:    mf_bytes = 9'd108;
      2'd1:    mf_bytes = 9'd144;
      2'd2:    mf_bytes = 9'd216;
      default: mf_bytes = 9'd432;
    endcase
  endfunction

endpackage

// File: rtl/vtpkt_phase.sv
module vtpkt_phase #(
  parameter int QW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_en,
  input  logic          mf_mark,
  input  logic [QW-1:0] quarter,
  output logic          synced,
  output logic          is_ovh
);

  logic [QW-1:0] qpos_q, qpos_d, cur;
  logic          sync_q, sync_d;

  always_comb begin
    cur    = mf_mark ? '0 : qpos_q;
    qpos_d = qpos_q;
    sync_d = sync_q;
    if (byte_en && (mf_mark || sync_q)) begin
      sync_d = 1'b1;
      qpos_d = (cur == quarter - 1'b1) ? '0 : cur + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qpos_q <= '0;
      sync_q <= 1'b0;
    end else begin
      qpos_q <= qpos_d;
      sync_q <= sync_d;
    end
  end

  assign synced = sync_q;
  assign is_ovh = byte_en && (mf_mark || (sync_q && (qpos_q == '0)));

  // R2: position inside the quarter stays below the quarter length
  a_r2_qpos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en && !mf_mark && sync_q) |-> (qpos_q < quarter));

  // R11: once aligned, alignment is kept until reset
  a_r11_sync_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |=> sync_q);

endmodule

// File: rtl/vtpkt_hdr_flags.sv
module vtpkt_hdr_flags
  import vtpkt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             neg_evt,
  input  logic             pos_evt,
  input  logic             ais_v,
  input  logic             rdi,
  input  logic             dba,
  input  logic             structured,
  input  logic             seal,
  input  logic [PTR_W-1:0] ptr,
  output logic [31:0]      hdr_word
);

  logic             n_lat_q, n_lat_d, p_lat_q, p_lat_d;
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic             n_now, p_now, hdr_n, hdr_p;

  always_comb begin
    n_now   = n_lat_q | neg_evt;
    p_now   = p_lat_q | pos_evt;
    hdr_n   = structured & (ais_v | n_now);
    hdr_p   = structured & (ais_v | p_now);
    n_lat_d = n_now;
    p_lat_d = p_now;
    seq_d   = seq_q;
    if (seal) begin
      n_lat_d = 1'b0;
      p_lat_d = 1'b0;
      seq_d   = seq_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_lat_q <= 1'b0;
      p_lat_q <= 1'b0;
      seq_q   <= '0;
    end else begin
      n_lat_q <= n_lat_d;
      p_lat_q <= p_lat_d;
      seq_q   <= seq_d;
    end
  end

  assign hdr_word = {1'b0, rdi, dba, hdr_n, hdr_p, ptr, seq_q};

  // R6: sequence advances by exactly one per completed fragment
  a_r6_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    seal |=> (seq_q == $past(seq_q) + 1'b1));

  // R6: sequence holds between completions
  a_r6_seq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !seal |=> (seq_q == $past(seq_q)));

  // R7: a latched event survives until a fragment completes
  a_r7_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (n_lat_q && !seal) |=> n_lat_q);

endmodule

// File: rtl/vtpkt_frag_writer.sv
module vtpkt_frag_writer
  import vtpkt_pkg::*;
#(
  parameter int MAX_PAY = 432,
  parameter int LEN_W   = 9,
  parameter int QW      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_mf_start,
  input  logic             in_v5,
  input  logic [1:0]       cfg_kind,
  input  logic             cfg_structured,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             synced,
  input  logic             is_ovh,
  input  logic [31:0]      hdr_word,
  output logic [QW-1:0]    quarter,
  output logic             eff_struct,
  output logic             seal,
  output logic [PTR_W-1:0] ptr_now,
  input  logic             rd_bank,
  input  logic [LEN_W-1:0] rd_idx,
  input  logic             rd_clr,
  output logic [7:0]       rd_byte,
  output logic [31:0]      rd_hdr,
  output logic [LEN_W-1:0] rd_len,
  output logic [1:0]       ready
);

  localparam int NBANK = 2;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [1:0] kind,
                                                 input logic st,
                                                 input logic [LEN_W-1:0] req);
    int lim;
    int r;
    lim = int'(mf_bytes(kind)) - (st ? 4 : 0);
    if (lim > MAX_PAY) lim = MAX_PAY;
    r = int'(req);
    if (r == 0) r = 1;
    if (r > lim) r = lim;
    return LEN_W'(r);
  endfunction

  logic [1:0]       act_kind_q, act_kind_d, eff_kind;
  logic             act_struct_q, act_struct_d;
  logic [LEN_W-1:0] act_len_q, act_len_d, eff_len;
  logic [LEN_W-1:0] wcnt_q, wcnt_d;
  logic             wbank_q, wbank_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             load, take, mark;

  logic [31:0]      hdr_q   [NBANK];
  logic [LEN_W-1:0] len_q   [NBANK];
  logic [NBANK-1:0] ready_q, ready_d;
  logic [7:0]       bank_rd [NBANK];

  always_comb begin
    load       = in_valid && in_mf_start && (wcnt_q == '0);
    eff_kind   = load ? cfg_kind : act_kind_q;
    eff_struct = load ? cfg_structured : act_struct_q;
    eff_len    = load ? clamp_len(cfg_kind, cfg_structured, cfg_len) : act_len_q;
    quarter    = QW'(mf_bytes(eff_kind) >> 2);
    take       = in_valid && (synced || in_mf_start) && !(eff_struct && is_ovh);
    mark       = eff_struct ? in_v5 : in_mf_start;
    ptr_now    = (take && mark && (ptr_q == PTR_NONE)) ? PTR_W'(wcnt_q) : ptr_q;
    seal       = take && (wcnt_q == eff_len - 1'b1);

    act_kind_d   = act_kind_q;
    act_struct_d = act_struct_q;
    act_len_d    = act_len_q;
    if (load) begin
      act_kind_d   = cfg_kind;
      act_struct_d = cfg_structured;
      act_len_d    = eff_len;
    end

    wcnt_d  = wcnt_q;
    wbank_d = wbank_q;
    ptr_d   = ptr_q;
    if (seal) begin
      wcnt_d  = '0;
      wbank_d = ~wbank_q;
      ptr_d   = PTR_NONE;
    end else if (take) begin
      wcnt_d  = wcnt_q + 1'b1;
      ptr_d   = ptr_now;
    end

    ready_d = ready_q;
    if (rd_clr) ready_d[rd_bank] = 1'b0;
    if (seal)   ready_d[wbank_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_kind_q   <= 2'd0;
      act_struct_q <= 1'b0;
      act_len_q    <= LEN_W'(1);
      wcnt_q       <= '0;
      wbank_q      <= 1'b0;
      ptr_q        <= PTR_NONE;
      ready_q      <= '0;
    end else begin
      act_kind_q   <= act_kind_d;
      act_struct_q <= act_struct_d;
      act_len_q    <= act_len_d;
      wcnt_q       <= wcnt_d;
      wbank_q      <= wbank_d;
      ptr_q        <= ptr_d;
      ready_q      <= ready_d;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [7:0] mem [MAX_PAY];

    always_ff @(posedge clk) begin
      if (take && (wbank_q == 1'(b))) mem[wcnt_q] <= in_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hdr_q[b] <= '0;
        len_q[b] <= LEN_W'(1);
      end else if (seal && (wbank_q == 1'(b))) begin
        hdr_q[b] <= hdr_word;
        len_q[b] <= eff_len;
      end
    end

    assign bank_rd[b] = mem[rd_idx];
  end

  assign rd_byte = bank_rd[rd_bank];
  assign rd_hdr  = hdr_q[rd_bank];
  assign rd_len  = len_q[rd_bank];
  assign ready   = ready_q;

  // R11: a bank is never refilled before it has been sent
  a_r11_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    seal |-> !ready_q[wbank_q]);

  // R10: active fragment length stays inside 1..MAX_PAY
  a_r10_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (act_len_q != '0) && (int'(act_len_q) <= MAX_PAY));

  // R11: configuration only moves at an aligned fragment start
  a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((act_len_q == $past(act_len_q)) && (act_kind_q == $past(act_kind_q))));

  // R4: a recorded pointer is kept until the fragment completes
  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!seal && (ptr_q != PTR_NONE)) |=> (ptr_q == $past(ptr_q)));

endmodule

// File: rtl/vtpkt_emitter.sv
module vtpkt_emitter
  import vtpkt_pkg::*;
#(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ready,
  input  logic [7:0]       rd_byte,
  input  logic [31:0]      rd_hdr,
  input  logic [LEN_W-1:0] rd_len,
  output logic             rd_bank,
  output logic [LEN_W-1:0] rd_idx,
  output logic             rd_clr,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop
);

  em_state_e        state_q, state_d;
  logic             bank_q, bank_d;
  logic [LEN_W-1:0] idx_q, idx_d;
  logic [1:0]       hb_q, hb_d;

  always_comb begin
    state_d   = state_q;
    bank_d    = bank_q;
    idx_d     = idx_q;
    hb_d      = hb_q;
    out_valid = 1'b0;
    out_data  = 8'h00;
    out_sop   = 1'b0;
    out_eop   = 1'b0;
    rd_clr    = 1'b0;
    case (state_q)
      EM_IDLE: begin
        if (ready[bank_q]) begin
          state_d = EM_HDR;
          hb_d    = 2'd0;
        end
      end
      EM_HDR: begin
        out_valid = 1'b1;
        out_data  = rd_hdr[{~hb_q, 3'b000} +: 8];
        out_sop   = (hb_q == 2'd0);
        if (hb_q == 2'd3) begin
          state_d = EM_PAY;
          idx_d   = '0;
        end else begin
          hb_d = hb_q + 1'b1;
        end
      end
      EM_PAY: begin
        out_valid = 1'b1;
        out_data  = rd_byte;
        if (idx_q == rd_len - 1'b1) begin
          out_eop = 1'b1;
          rd_clr  = 1'b1;
          bank_d  = ~bank_q;
          state_d = EM_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: state_d = EM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EM_IDLE;
      bank_q  <= 1'b0;
      idx_q   <= '0;
      hb_q    <= 2'd0;
    end else begin
      state_q <= state_d;
      bank_q  <= bank_d;
      idx_q   <= idx_d;
      hb_q    <= hb_d;
    end
  end

  assign rd_bank = bank_q;
  assign rd_idx  = idx_q;

  // R1: start marker is a lone header byte
  a_r1_sop_alone: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> (out_valid && !out_eop));

  // R1: a gap follows every packet end
  a_r1_eop_gap: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |=> !out_valid);

  // R1: only a completed bank is ever sent
  a_r1_send_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ready[bank_q]);

endmodule

// File: rtl/vtpkt_packetizer.sv
module vtpkt_packetizer
  import vtpkt_pkg::*;
#(
  parameter int MAX_PAY = 432,
  localparam int LEN_W  = $clog2(MAX_PAY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_mf_start,
  input  logic             in_v5,
  input  logic             neg_evt,
  input  logic             pos_evt,
  input  logic             ais_v,
  input  logic             rdi,
  input  logic             dba_flag,
  input  logic [1:0]       cfg_kind,
  input  logic             cfg_structured,
  input  logic [LEN_W-1:0] cfg_len,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop
);

  logic [QTR_W-1:0] quarter;
  logic             synced, is_ovh, eff_struct, seal, rd_bank, rd_clr;
  logic [PTR_W-1:0] ptr_now;
  logic [31:0]      hdr_word, rd_hdr;
  logic [LEN_W-1:0] rd_idx, rd_len;
  logic [7:0]       rd_byte;
  logic [1:0]       ready;

  vtpkt_phase #(.QW(QTR_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .byte_en(in_valid), .mf_mark(in_mf_start),
    .quarter(quarter), .synced(synced), .is_ovh(is_ovh)
  );

  vtpkt_hdr_flags u_flags (
    .clk(clk), .rst_n(rst_n), .neg_evt(neg_evt), .pos_evt(pos_evt),
    .ais_v(ais_v), .rdi(rdi), .dba(dba_flag), .structured(eff_struct),
    .seal(seal), .ptr(ptr_now), .hdr_word(hdr_word)
  );

  vtpkt_frag_writer #(.MAX_PAY(MAX_PAY), .LEN_W(LEN_W), .QW(QTR_W)) u_writer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_mf_start(in_mf_start), .in_v5(in_v5), .cfg_kind(cfg_kind),
    .cfg_structured(cfg_structured), .cfg_len(cfg_len), .synced(synced),
    .is_ovh(is_ovh), .hdr_word(hdr_word), .quarter(quarter),
    .eff_struct(eff_struct), .seal(seal), .ptr_now(ptr_now),
    .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_clr(rd_clr), .rd_byte(rd_byte),
    .rd_hdr(rd_hdr), .rd_len(rd_len), .ready(ready)
  );

  vtpkt_emitter #(.LEN_W(LEN_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .ready(ready), .rd_byte(rd_byte),
    .rd_hdr(rd_hdr), .rd_len(rd_len), .rd_bank(rd_bank), .rd_idx(rd_idx),
    .rd_clr(rd_clr), .out_valid(out_valid), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop)
  );

endmodule

// File: tb/vtpkt_packetizer_bench.sv
module vtpkt_packetizer_bench;

  localparam int GAP = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_mf_start = 1'b0, in_v5 = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       neg_evt = 1'b0, pos_evt = 1'b0, ais_v = 1'b0, rdi = 1'b0, dba_flag = 1'b0;
  logic [1:0] cfg_kind = 2'd0;
  logic       cfg_structured = 1'b0;
  logic [8:0] cfg_len = 9'd1;
  logic       out_valid, out_sop, out_eop;
  logic [7:0] out_data;

  always #2 clk = ~clk;

  vtpkt_packetizer u_vtpkt_packetizer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_mf_start(in_mf_start), .in_v5(in_v5), .neg_evt(neg_evt),
    .pos_evt(pos_evt), .ais_v(ais_v), .rdi(rdi), .dba_flag(dba_flag),
    .cfg_kind(cfg_kind), .cfg_structured(cfg_structured), .cfg_len(cfg_len),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
  );

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string cur_tag = "R1";

  logic [9:0] exp_q[$];
  logic [7:0] m_pay[$];
  bit          m_synced, m_struct, m_n, m_p;
  int          m_len, m_cnt, m_ptr;
  logic [13:0] m_seq;

  task automatic check(input string tag, input bit ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic int mfb(input int kind);
    case (kind)
      0: return 108;
      1: return 144;
      2: return 216;
      default: return 432;
    endcase
  endfunction

  function automatic int clamp(input int kind, input bit st, input int req);
    int lim = mfb(kind) - (st ? 4 : 0);
    if (lim > 432) lim = 432;
    if (req == 0) return 1;
    return (req > lim) ? lim : req;
  endfunction

  task automatic model_reset();
    m_synced = 0; m_struct = 0; m_n = 0; m_p = 0;
    m_len = 1; m_cnt = 0; m_ptr = 'h1FF; m_seq = '0;
    m_pay.delete();
    exp_q.delete();
  endtask

  task automatic model_step(input logic [7:0] b, input bit mf, input bit v5,
                            input bit ovh, input bit nev, input bit pev);
    bit mark;
    logic [31:0] hdr;
    bit hn, hp;
    m_n = m_n | nev;
    m_p = m_p | pev;
    if (mf && m_cnt == 0) begin
      m_len = clamp(int'(cfg_kind), cfg_structured, int'(cfg_len));
      m_struct = cfg_structured;
    end
    if (mf) m_synced = 1;
    if (!m_synced) return;
    if (m_struct && ovh) return;
    mark = m_struct ? v5 : mf;
    if (mark && m_ptr == 'h1FF) m_ptr = m_cnt;
    m_pay.push_back(b);
    m_cnt++;
    if (m_cnt == m_len) begin
      hn = m_struct && (ais_v || m_n);
      hp = m_struct && (ais_v || m_p);
      hdr = {1'b0, rdi, dba_flag, hn, hp, 13'(m_ptr), m_seq};
      for (int k = 0; k < 4; k++)
        exp_q.push_back({(k == 0), 1'b0, hdr[8*(3-k) +: 8]});
      for (int k = 0; k < m_len; k++)
        exp_q.push_back({1'b0, (k == m_len - 1), m_pay[k]});
      m_pay.delete();
      m_n = 0; m_p = 0; m_cnt = 0; m_ptr = 'h1FF;
      m_seq = m_seq + 1'b1;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (exp_q.size() == 0) begin
        check(cur_tag, 1'b0, {out_sop, out_eop, out_data}, 0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        check(cur_tag, {out_sop, out_eop, out_data} == e, {out_sop, out_eop, out_data}, e);
      end
    end
  end

  task automatic send_byte(input logic [7:0] b, input bit mf, input bit v5,
                           input bit ovh, input bit nev, input bit pev);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_mf_start = mf; in_v5 = v5;
    neg_evt = nev; pos_evt = pev;
    model_step(b, mf, v5, ovh, nev, pev);
    @(negedge clk);
    in_valid = 1'b0; in_mf_start = 1'b0; in_v5 = 1'b0; neg_evt = 1'b0; pos_evt = 1'b0;
    repeat (GAP - 2) @(negedge clk);
  endtask

  task automatic run_stream(input int kind, input int nbytes, input int start_pos,
                            input int v5pos, input int n_at, input int p_at,
                            input int chg_at, input int chg_len);
    int mf_len = mfb(kind);
    int q = mf_len / 4;
    for (int i = 0; i < nbytes; i++) begin
      int p = (start_pos + i) % mf_len;
      if (i == chg_at) cfg_len = 9'(chg_len);
      send_byte(8'((i * 7 + kind * 13 + start_pos) & 255), p == 0, p == v5pos,
                (p % q) == 0, i == n_at, i == p_at);
    end
  endtask

  task automatic do_reset(input int kind, input bit st, input int len);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_kind = 2'(kind); cfg_structured = st; cfg_len = 9'(len);
    ais_v = 0; rdi = 0; dba_flag = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drain(input string tag);
    repeat (700) @(negedge clk);
    check(tag, exp_q.size() == 0, exp_q.size(), 0);
  endtask

  initial begin
    do_reset(0, 0, 50);
    @(negedge clk);
    // R1: idle outputs after reset
    check("R1", !out_valid && !out_sop && !out_eop, {out_valid, out_sop, out_eop}, 0);

    // R1 R5 R7: unstructured, pointer on V1, events not reported
    cur_tag = "R1 R5 R7";
    run_stream(0, 324, 0, 5, 30, 60, -1, 0);
    drain(cur_tag);

    // R3 R4 R7: structured at the limit; event on the completing byte
    do_reset(0, 1, 104);
    cur_tag = "R3 R4 R7";
    run_stream(0, 324, 0, 1, 107, 108, -1, 0);
    drain(cur_tag);

    // R2 R7: structured VT2, short fragments, V5 absent in most
    do_reset(1, 1, 30);
    cur_tag = "R2 R7";
    run_stream(1, 432, 0, 40, 50, 200, -1, 0);
    drain(cur_tag);

    // R8 R9: AIS-V overrides events; defect flags sampled at completion
    do_reset(2, 1, 100);
    cur_tag = "R8 R9";
    ais_v = 1; rdi = 1; dba_flag = 0;
    run_stream(2, 432, 0, 3, 10, -1, -1, 0);
    ais_v = 0; rdi = 0; dba_flag = 1;
    run_stream(2, 216, 0, 3, 20, -1, -1, 0);
    drain(cur_tag);

    // R10: length clamp at both ends
    do_reset(3, 0, 500);
    cur_tag = "R10";
    run_stream(3, 864, 0, 7, -1, -1, -1, 0);
    drain(cur_tag);
    do_reset(0, 1, 0);
    run_stream(0, 60, 0, 2, -1, -1, -1, 0);
    drain(cur_tag);

    // R11: pre-alignment bytes dropped, length change waits for aligned start
    do_reset(0, 0, 54);
    cur_tag = "R11";
    run_stream(0, 400, 10, 5, -1, -1, 150, 60);
    drain(cur_tag);

    // R6: sequence wrap with one-byte fragments
    do_reset(0, 0, 1);
    cur_tag = "R6";
    run_stream(0, 16390, 0, 5, -1, -1, -1, 0);
    drain(cur_tag);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule